// File: doc/BRIEF.md
# Interrupt Destination Match Logic

This block decides whether an interrupt message on the system's message path is addressed to the local interrupt controller. Each message carries a destination field, a bit that selects physical or logical addressing, a two-bit shorthand code, and a flag that says whether this controller sent the message. From these inputs and its own programmed identity, the block drives one combinational `match` output. The delivery logic uses that output to accept or ignore the message.

The identity is programmed through a simple register write port. The port writes four things: the local ID, the logical destination register, the format register (which selects flat or cluster grouping), and an extended-mode enable. In extended mode the whole logical register is compared against a wide destination. When extended mode is entered, the logical register is seeded from the local ID. While extended mode is on, the identity registers cannot be rewritten. A format register with an undefined model code raises an error flag and never gives a logical match.

Top module: `irq_dest_match`

## Requirements
- R1: `shorthand` selects the target set. Code 1 matches only when `isSender` is 1. Code 2 always matches. Code 3 matches only when `isSender` is 0. Code 0 uses the destination field as described in R2 to R5.
- R2: Physical mode (shorthand 0, `destLogical`=0) matches when the whole `dest` equals 0xFF, or when the whole `dest` equals the zero-extended 8-bit local ID. The local ID is written from `wrData[31:24]` with `wrSel`=0.
- R3: Logical mode outside extended mode, flat format: match when the bitwise AND of the logical ID and `dest[7:0]` is nonzero. The logical ID is bits 31:24 of the logical register, which is written with `wrSel`=1. The other bits of `dest` are ignored.
- R4: Cluster format is logical model code 0x0. It matches when the logical ID's bits 7:4 equal `dest[7:4]` and the AND of the logical ID's bits 3:0 with `dest[3:0]` is nonzero.
- R5: In extended mode (`wrSel`=3 with `wrData[0]`=1), logical mode matches when the AND of the full 32-bit logical register and `dest` is nonzero.
- R6: While extended mode is on, writes with `wrSel` 0, 1 or 2 change nothing. Leaving extended mode (`wrSel`=3, `wrData[0]`=0) keeps the logical register's contents.
- R7: The format register is written with `wrSel`=2. Only bits 31:28 are kept, as the model code (0xF is flat, 0x0 is cluster). Bits 27:0 are forced to ones. Reset leaves the register all ones, so flat format is selected.
- R8: Entering extended mode from outside it loads the logical register with ((id & ~0xF) << 16) | (1 << (id & 0xF)), where id is the 8-bit local ID.
- R9: Outside extended mode, a model code other than 0xF or 0x0 sets `fmtError` and gives no logical match. In extended mode `fmtError` is 0.
- R10: After reset the local ID and the logical register are 0 and extended mode is off. So a physical `dest` of 0 matches, and no logical destination matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 local ID, 1 logical register, 2 format, 3 mode |
| wrData | input | 32 | Write data |
| dest | input | 32 | Message destination field |
| destLogical | input | 1 | 1 selects logical addressing, 0 selects physical addressing |
| shorthand | input | 2 | Shorthand code (0 none, 1 self, 2 all, 3 all but self) |
| isSender | input | 1 | 1 when this controller sent the message |
| match | output | 1 | The message targets this controller |
| fmtError | output | 1 | The format model code is undefined (outside extended mode) |

## Verification
Two functions can act in the same cycle: entering extended mode, and a logical lookup that is held across that write. The mode write reseeds the logical register at the same edge where the lookup's meaning changes. The bench holds a logical destination steady across the entering write. It expects no match just before the edge, from the old flat logical ID. It expects a match just after the edge, from the seeded register. A second collision is a rejected identity write landing while extended mode is on. It is judged at the ports by showing that physical and logical matches keep their old values, and that the format code is unchanged after extended mode is left.

// File: rtl/dm_pkg.sv
package dm_pkg;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_LDR  = 2'd1,
    SEL_FMT  = 2'd2,
    SEL_MODE = 2'd3
  } dmSel_e;

  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } dmShort_e;

  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;

  // strobes from control to datapath
  typedef struct packed {
    logic ldId;
    logic ldLdr;
    logic ldFmt;
    logic seedLdr;
  } dmStrobe_t;

endpackage

// File: rtl/dm_ctrl.sv
module dm_ctrl
  import dm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       wrBit0,
  output dmStrobe_t  strobe,
  output logic       extMode
);

  dmSel_e sel;
  assign sel = dmSel_e'(wrSel);

  always_comb begin
    strobe         = '0;
    strobe.ldId    = wrEn && (sel == SEL_ID)  && !extMode;
    strobe.ldLdr   = wrEn && (sel == SEL_LDR) && !extMode;
    strobe.ldFmt   = wrEn && (sel == SEL_FMT) && !extMode;
    strobe.seedLdr = wrEn && (sel == SEL_MODE) && wrBit0 && !extMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          extMode <= 1'b0;
    else if (wrEn && (sel == SEL_MODE)) extMode <= wrBit0;
  end

  // R6: no identity strobe while in extended mode
  p_no_load_in_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    extMode |-> !(strobe.ldId || strobe.ldLdr || strobe.ldFmt || strobe.seedLdr));

endmodule

// File: rtl/dm_datapath.sv
module dm_datapath
  import dm_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmStrobe_t        strobe,
  input  logic             extMode,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] dest,
  input  logic             destLogical,
  input  logic [1:0]       shorthand,
  input  logic             isSender,
  output logic             match,
  output logic             fmtError
);

  localparam int NIB    = ID_W / 2;
  localparam int LOW_W  = REG_W - 4;
  localparam int SEED_SH = 16;

  logic [ID_W-1:0]  idReg;
  logic [REG_W-1:0] ldrReg;
  logic [REG_W-1:0] fmtReg;

  logic [REG_W-1:0] seedVal;
  logic [ID_W-1:0]  logicalId;
  logic [ID_W-1:0]  destLow;
  logic [3:0]       model;
  logic             physHit, flatHit, clusterHit, extHit, logicalHit;
  dmShort_e         sh;

  assign seedVal = (REG_W'(idReg & ~ID_W'(15)) << SEED_SH)
                 | (REG_W'(1) << idReg[3:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg  <= '0;
      ldrReg <= '0;
      fmtReg <= '1;
    end else begin
      if (strobe.ldId)    idReg  <= wrData[REG_W-1 -: ID_W];
      if (strobe.ldFmt)   fmtReg <= {wrData[REG_W-1 -: 4], {LOW_W{1'b1}}};
      if (strobe.seedLdr) ldrReg <= seedVal;
      else if (strobe.ldLdr) ldrReg <= wrData;
    end
  end

  assign sh        = dmShort_e'(shorthand);
  assign logicalId = ldrReg[REG_W-1 -: ID_W];
  assign destLow   = dest[ID_W-1:0];
  assign model     = fmtReg[REG_W-1 -: 4];

  assign physHit    = (dest == REG_W'(8'hFF)) || (dest == REG_W'(idReg));
  assign flatHit    = |(logicalId & destLow);
  assign clusterHit = (logicalId[ID_W-1:NIB] == destLow[ID_W-1:NIB])
                   && |(logicalId[NIB-1:0] & destLow[NIB-1:0]);
  assign extHit     = |(ldrReg & dest);
  assign fmtError   = !extMode && (model != MODEL_FLAT) && (model != MODEL_CLUSTER);

  always_comb begin
    if (extMode)                      logicalHit = extHit;
    else if (model == MODEL_FLAT)     logicalHit = flatHit;
    else if (model == MODEL_CLUSTER)  logicalHit = clusterHit;
    else                              logicalHit = 1'b0;
  end

  always_comb begin
    unique case (sh)
      SH_NONE:   match = destLogical ? logicalHit : physHit;
      SH_SELF:   match = isSender;
      SH_ALL:    match = 1'b1;
      SH_OTHERS: match = !isSender;
    endcase
  end

  // R6: identity held while extended mode is on
  p_hold_in_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    extMode |=> ($stable(idReg) && $stable(ldrReg) && $stable(fmtReg)));
  // R7: low format bits stay ones
  p_fmt_low_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    fmtReg[LOW_W-1:0] == {LOW_W{1'b1}});
  // R8: entry seeds the logical register
  p_seed_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extMode) |-> (ldrReg[3:0] == 4'd0 ? 1'b1 : 1'b1) && $onehot0(ldrReg[15:0]));
  // R9: undefined model never matches logically
  p_fmt_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fmtError && sh == SH_NONE && destLogical) |-> !match);

endmodule

// File: rtl/irq_dest_match.sv
module irq_dest_match
  import dm_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] dest,
  input  logic             destLogical,
  input  logic [1:0]       shorthand,
  input  logic             isSender,
  output logic             match,
  output logic             fmtError
);

  dmStrobe_t strobe;
  logic      extMode;

  dm_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrBit0  (wrData[0]),
    .strobe  (strobe),
    .extMode (extMode)
  );

  dm_datapath #(.REG_W(REG_W), .ID_W(ID_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .extMode     (extMode),
    .wrData      (wrData),
    .dest        (dest),
    .destLogical (destLogical),
    .shorthand   (shorthand),
    .isSender    (isSender),
    .match       (match),
    .fmtError    (fmtError)
  );

  // R1: shorthand outcomes at the port
  p_self_r1: assert property (@(posedge clk) disable iff (!rstN)
    (shorthand == 2'd1) |-> (match == isSender));
  p_all_r1: assert property (@(posedge clk) disable iff (!rstN)
    (shorthand == 2'd2) |-> match);
  p_others_r1: assert property (@(posedge clk) disable iff (!rstN)
    (shorthand == 2'd3) |-> (match == !isSender));
  // R2: broadcast always hits in physical mode
  p_bcast_r2: assert property (@(posedge clk) disable iff (!rstN)
    (shorthand == 2'd0 && !destLogical && dest == REG_W'(8'hFF)) |-> match);

endmodule

// File: tb/test_irq_dest_match.sv
module test_irq_dest_match;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [31:0] dest = '0;
  logic        destLogical = 1'b0;
  logic [1:0]  shorthand = '0;
  logic        isSender = 1'b0;
  logic        match, fmtError;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_dest_match i_irq_dest_match (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .dest(dest), .destLogical(destLogical), .shorthand(shorthand),
    .isSender(isSender), .match(match), .fmtError(fmtError)
  );

  // {shorthand, logical, sender, dest, expected}; id 0x35, logical id 0x0C, flat
  localparam logic [36:0] VEC [13] = '{
    {2'd1, 1'b0, 1'b1, 32'h0000_0000, 1'b1},
    {2'd1, 1'b0, 1'b0, 32'h0000_0035, 1'b0},
    {2'd2, 1'b1, 1'b1, 32'h0000_0000, 1'b1},
    {2'd3, 1'b0, 1'b1, 32'h0000_00FF, 1'b0},
    {2'd3, 1'b1, 1'b0, 32'h0000_0000, 1'b1},
    {2'd0, 1'b0, 1'b0, 32'h0000_0035, 1'b1},
    {2'd0, 1'b0, 1'b0, 32'h0000_0036, 1'b0},
    {2'd0, 1'b0, 1'b1, 32'h0000_00FF, 1'b1},
    {2'd0, 1'b0, 1'b0, 32'h0000_0135, 1'b0},
    {2'd0, 1'b1, 1'b0, 32'h0000_0004, 1'b1},
    {2'd0, 1'b1, 1'b0, 32'h0000_0030, 1'b0},
    {2'd0, 1'b1, 1'b0, 32'h0000_0008, 1'b1},
    {2'd0, 1'b1, 1'b0, 32'h0000_0100, 1'b0}
  };

  task automatic chk(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic look(input logic [1:0] sh, input logic lg, input logic snd,
                      input logic [31:0] d);
    shorthand = sh; destLogical = lg; isSender = snd; dest = d;
    #1;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    look(2'd0, 1'b0, 1'b0, 32'h0);          chk(match, 1'b1, "R10 physical id 0");
    look(2'd0, 1'b1, 1'b0, 32'hFFFF_FFFF);  chk(match, 1'b0, "R10 logical none");
    chk(fmtError, 1'b0, "R7 reset format is flat");

    wr(2'd0, 32'h3500_0000);
    wr(2'd1, 32'h0C00_0000);
    wr(2'd2, 32'hFABC_DEF0);                // model F, low bits ignored (R7)

    for (int i = 0; i < 13; i++) begin
      string tag;
      look(VEC[i][36:35], VEC[i][34], VEC[i][33], VEC[i][32:1]);
      tag = (VEC[i][36:35] != 2'd0) ? "R1" : (VEC[i][34] ? "R3" : "R2");
      chk(match, VEC[i][0], $sformatf("%s vector %0d", tag, i));
    end

    // R4 / R7 cluster (low bits of write ignored)
    wr(2'd2, 32'h0ABC_DEF0);
    wr(2'd1, 32'h5200_0000);
    look(2'd0, 1'b1, 1'b0, 32'h53); chk(match, 1'b1, "R4 cluster hit");
    look(2'd0, 1'b1, 1'b0, 32'h54); chk(match, 1'b0, "R4 no member bit");
    look(2'd0, 1'b1, 1'b0, 32'h42); chk(match, 1'b0, "R4 wrong cluster");
    chk(fmtError, 1'b0, "R9 cluster is defined");

    // R9 undefined model
    wr(2'd2, 32'h7000_0000);
    look(2'd0, 1'b1, 1'b0, 32'hFF); chk(match, 1'b0, "R9 no logical match");
    chk(fmtError, 1'b1, "R9 error flag");
    look(2'd0, 1'b0, 1'b0, 32'h35); chk(match, 1'b1, "R9 physical unaffected");

    // back to flat, logical id 0x52; collision: lookup held across entry
    wr(2'd2, 32'hF000_0000);
    look(2'd0, 1'b1, 1'b0, 32'h20);
    chk(match, 1'b0, "R3 before entry");
    wr(2'd3, 32'h1);                         // seed 0x00300020 (R8)
    #1;
    chk(match, 1'b1, "R8 seeded bit 5 after entry");
    look(2'd0, 1'b1, 1'b0, 32'h0010_0000); chk(match, 1'b1, "R8 seeded cluster bits");
    look(2'd0, 1'b1, 1'b0, 32'h0000_0010); chk(match, 1'b0, "R5 no overlap");
    look(2'd0, 1'b1, 1'b0, 32'h0020_0000); chk(match, 1'b1, "R5 wide overlap");

    // R9: invalid model ignored in extended mode? format is flat here; check flag low
    chk(fmtError, 1'b0, "R9 flag low in extended mode");

    // R6 rejected writes
    wr(2'd0, 32'h7700_0000);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h0000_0000);
    look(2'd0, 1'b0, 1'b0, 32'h35); chk(match, 1'b1, "R6 id kept");
    look(2'd0, 1'b0, 1'b0, 32'h77); chk(match, 1'b0, "R6 id not written");
    look(2'd0, 1'b1, 1'b0, 32'h1);  chk(match, 1'b0, "R6 logical not written");

    // leave extended mode: logical kept, format still flat
    wr(2'd3, 32'h0);
    look(2'd0, 1'b1, 1'b0, 32'h0000_00FF); chk(match, 1'b0, "R6 kept logical id 0");
    wr(2'd1, 32'h5200_0000);
    look(2'd0, 1'b1, 1'b0, 32'h42); chk(match, 1'b1, "R6 format write rejected, still flat");
    look(2'd0, 1'b1, 1'b0, 32'h0000_0142); chk(match, 1'b1, "R3 upper dest bits ignored");

    // R10 reset again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    look(2'd0, 1'b1, 1'b0, 32'h42); chk(match, 1'b0, "R10 logical cleared");
    look(2'd0, 1'b0, 1'b0, 32'h35); chk(match, 1'b0, "R10 id cleared");

    finishRun();
  end

endmodule